// File: doc/BRIEF.md
# Configuration Download Sequencer

This block fills a bank of volatile configuration registers from a paged non-volatile byte store. The store holds 512 bytes at host addresses F800h to F9FFh, in 16 pages of 32 bytes. Only the first seven pages, F800h to F8DFh, carry configuration. Each byte at F8xxh lands in the register whose address is the low byte xx. Page 7 and the user pages 8 to 15 are never copied.

A download starts on its own when reset is released. Host software can start another one by writing a 1 to bit 2 of the update register at 90h. While a download is running the block raises a busy flag. The host side is locked out during that time: writes are dropped and reads return zero. When the last byte is stored, the trigger bit is cleared and a one-cycle done pulse is issued.

The store is modelled as a synchronous memory with a parameterised read latency. After reset it holds a fixed power-on image. Host writes to its address window replace bytes one at a time.

Top module: `cfg_loader`

## Requirements
- R1: While rst_ni is low, busy_o is 1 and done_o is 0. A download begins on the first clock edge after reset is released.
- R2: After reset, the store byte at offset k (address F800h+k, k from 0 to 511) holds (7*k+3) mod 256.
- R3: A download issues one store read per byte in ascending order from F800h to F8DFh. It writes each byte to config register (address − F800h), for registers 00h to DFh.
- R4: Bytes of pages 7 to 15 (F8E0h to F9FFh) never reach a register. A host read of any address from E0h upward that is outside the store window returns 0.
- R5: When idle, a host write to 90h with bit 2 set stores the byte and starts a user download on that edge. With bit 2 clear, the write only stores the byte.
- R6: On the edge of the final register write, bit 2 of register 90h is forced to 0. Its other bits keep the value copied from F890h.
- R7: For a user download, busy_o is high for exactly 224 + RD_LAT clock cycles after the triggering write edge. It falls on the edge of the final register write.
- R8: done_o is high for exactly one cycle per download, the cycle in which busy_o has just fallen.
- R9: While busy_o is high, host writes are ignored. This includes a write that sets the trigger bit, so no second download follows. Host reads return 0.
- R10: When idle, a host write to 00h to DFh updates that register, and a write to F800h to F9FFh updates that store byte. Host reads of 00h to DFh return the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 16 | Host address for reads and writes |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, combinational from host_addr_i |
| busy_o | output | 1 | Download in progress; host lockout |
| done_o | output | 1 | One-cycle pulse when a download ends |

## Verification
The hardest case to reach is the copied byte for the update register itself carrying a set trigger bit. If the end-of-download clear were missing or applied in the wrong order, the block would start again or leave the bit set. The bench reaches this case by using idle host writes to load FFh at F890h, together with a new image for the rest of the configuration pages. It then starts a download from software and checks that 90h reads FBh afterwards and that busy stays low. A second scenario sends a trigger and a register write in the middle of a download. It then checks that neither has any effect once done arrives.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 16;

  // power-on image of the store
  function automatic logic [DATA_W-1:0] nv_init_byte(int unsigned k);
    int unsigned v;
    v = (k * 7 + 3) % 256;
    return DATA_W'(v);
  endfunction
endpackage

// File: rtl/cfg_nvm_model.sv
module cfg_nvm_model
  import cfg_loader_pkg::*;
#(
  parameter int unsigned NV_BYTES = 512,
  parameter int unsigned IDX_W    = 9,
  parameter int unsigned RD_LAT   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [NV_BYTES];
  logic [RD_LAT-1:0]             pv_q;
  logic [RD_LAT-1:0][DATA_W-1:0] pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NV_BYTES; k++) mem_q[k] <= nv_init_byte(k);
    end else if (we_i) begin
      mem_q[wr_idx_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q <= '0;
      pd_q <= '0;
    end else begin
      pv_q[0] <= re_i;
      pd_q[0] <= mem_q[rd_idx_i];
      for (int s = 1; s < RD_LAT; s++) begin
        pv_q[s] <= pv_q[s-1];
        pd_q[s] <= pd_q[s-1];
      end
    end
  end

  assign rvalid_o = pv_q[RD_LAT-1];
  assign rdata_o  = pd_q[RD_LAT-1];
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq #(
  parameter int unsigned CFG_BYTES = 224,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned IDX_W     = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rvalid_i,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             wr_en_o,
  output logic [CNT_W-1:0] wr_addr_o,
  output logic             clr_trig_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] N_BYTES = CNT_W'(CFG_BYTES);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(CFG_BYTES - 1);

  logic             run_q, done_q;
  logic [CNT_W-1:0] iss_q, wr_q;
  logic             last_wr;

  assign rd_en_o    = run_q && (iss_q < N_BYTES);
  assign rd_idx_o   = IDX_W'(iss_q);
  assign wr_en_o    = run_q && rvalid_i;
  assign wr_addr_o  = wr_q;
  assign last_wr    = wr_en_o && (wr_q == LAST);
  assign clr_trig_o = last_wr;
  assign busy_o     = run_q;
  assign done_o     = done_q;

  // reset leaves run_q set: boot download starts on first edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
      iss_q  <= '0;
      wr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start_i) begin
          run_q <= 1'b1;
          iss_q <= '0;
          wr_q  <= '0;
        end
      end else begin
        if (rd_en_o) iss_q <= iss_q + 1'b1;
        if (wr_en_o) wr_q  <= wr_q + 1'b1;
        if (last_wr) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_loader_pkg::*;
#(
  parameter int unsigned CFG_BYTES = 224,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned TRIG_ADDR = 144,
  parameter int unsigned TRIG_BIT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seq_we_i,
  input  logic [CNT_W-1:0]  seq_addr_i,
  input  logic [DATA_W-1:0] seq_data_i,
  input  logic              clr_trig_i,
  input  logic              host_we_i,
  input  logic [CNT_W-1:0]  host_addr_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic [CNT_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [DATA_W-1:0] TRIG_MASK = DATA_W'(1) << TRIG_BIT;

  logic [DATA_W-1:0] regs [CFG_BYTES];

  for (genvar g = 0; g < CFG_BYTES; g++) begin : g_reg
    logic [DATA_W-1:0] q, nxt;
    logic seq_hit, host_hit;
    assign seq_hit  = seq_we_i  && (seq_addr_i  == CNT_W'(g));
    assign host_hit = host_we_i && (host_addr_i == CNT_W'(g));

    if (g == TRIG_ADDR) begin : g_trig
      always_comb begin
        nxt = q;
        if (seq_hit)       nxt = seq_data_i;
        else if (host_hit) nxt = host_data_i;
        if (clr_trig_i)    nxt = nxt & ~TRIG_MASK;
      end
    end else begin : g_plain
      always_comb begin
        nxt = q;
        if (seq_hit)       nxt = seq_data_i;
        else if (host_hit) nxt = host_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= nxt;
    end
    assign regs[g] = q;
  end

  assign rd_data_o = (rd_addr_i < CNT_W'(CFG_BYTES)) ? regs[rd_addr_i] : '0;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned       PAGE_BYTES = 32,
  parameter int unsigned       NV_PAGES   = 16,
  parameter int unsigned       CFG_PAGES  = 7,
  parameter int unsigned       RD_LAT     = 2,
  parameter logic [ADDR_W-1:0] NV_BASE    = 16'hF800,
  parameter int unsigned       TRIG_ADDR  = 144,
  parameter int unsigned       TRIG_BIT   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [15:0]       host_addr_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned NV_BYTES  = PAGE_BYTES * NV_PAGES;
  localparam int unsigned CFG_BYTES = PAGE_BYTES * CFG_PAGES;
  localparam int unsigned IDX_W     = $clog2(NV_BYTES);
  localparam int unsigned CNT_W     = $clog2(CFG_BYTES + 1);

  logic              seq_rd_en, seq_wr_en, seq_clr, nv_rvalid;
  logic [IDX_W-1:0]  seq_rd_idx;
  logic [CNT_W-1:0]  seq_wr_addr;
  logic [DATA_W-1:0] nv_rdata, rb_rdata;
  logic              host_ok, nv_hit, cfg_hit, trig;
  logic [ADDR_W-1:0] host_off;

  assign host_ok  = host_we_i && !busy_o;
  assign host_off = host_addr_i - NV_BASE;
  assign nv_hit   = (host_addr_i >= NV_BASE) && (host_off < ADDR_W'(NV_BYTES));
  assign cfg_hit  = host_addr_i < ADDR_W'(CFG_BYTES);
  assign trig     = host_ok && (host_addr_i == ADDR_W'(TRIG_ADDR)) && host_wdata_i[TRIG_BIT];

  cfg_seq #(.CFG_BYTES(CFG_BYTES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i    (trig),
    .rvalid_i   (nv_rvalid),
    .rd_en_o    (seq_rd_en),
    .rd_idx_o   (seq_rd_idx),
    .wr_en_o    (seq_wr_en),
    .wr_addr_o  (seq_wr_addr),
    .clr_trig_o (seq_clr),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  cfg_nvm_model #(.NV_BYTES(NV_BYTES), .IDX_W(IDX_W), .RD_LAT(RD_LAT)) u_nvm (
    .clk_i, .rst_ni,
    .we_i     (host_ok && nv_hit),
    .wr_idx_i (host_off[IDX_W-1:0]),
    .wdata_i  (host_wdata_i),
    .re_i     (seq_rd_en),
    .rd_idx_i (seq_rd_idx),
    .rvalid_o (nv_rvalid),
    .rdata_o  (nv_rdata)
  );

  cfg_regbank #(.CFG_BYTES(CFG_BYTES), .CNT_W(CNT_W),
                .TRIG_ADDR(TRIG_ADDR), .TRIG_BIT(TRIG_BIT)) u_regs (
    .clk_i, .rst_ni,
    .seq_we_i    (seq_wr_en),
    .seq_addr_i  (seq_wr_addr),
    .seq_data_i  (nv_rdata),
    .clr_trig_i  (seq_clr),
    .host_we_i   (host_ok && cfg_hit),
    .host_addr_i (host_addr_i[CNT_W-1:0]),
    .host_data_i (host_wdata_i),
    .rd_addr_i   (host_addr_i[CNT_W-1:0]),
    .rd_data_o   (rb_rdata)
  );

  assign host_rdata_o = (!busy_o && cfg_hit) ? rb_rdata : '0;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int unsigned CFG_BYTES = 224,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned IDX_W     = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic [7:0]       host_rdata_o,
  input logic             seq_rd_en,
  input logic [IDX_W-1:0] seq_rd_idx,
  input logic             seq_wr_en,
  input logic [CNT_W-1:0] seq_wr_addr
);
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r7_busy_fall_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r9_read_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> host_rdata_o == 8'h00);
  a_r3_rd_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_rd_en |-> seq_rd_idx < IDX_W'(CFG_BYTES));
  a_r3_wr_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_wr_en && $past(seq_wr_en)) |-> seq_wr_addr == CNT_W'($past(seq_wr_addr) + 1'b1));
  a_r3_wr_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_wr_en |-> busy_o);
endmodule

bind cfg_loader cfg_loader_chk #(.CFG_BYTES(CFG_BYTES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .host_rdata_o (host_rdata_o),
  .seq_rd_en    (seq_rd_en),
  .seq_rd_idx   (seq_rd_idx),
  .seq_wr_en    (seq_wr_en),
  .seq_wr_addr  (seq_wr_addr)
);

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
module cfg_loader_bench;
  localparam int RD_LAT = 2;
  localparam int NCFG   = 224;
  localparam int NNV    = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        busy, done;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_nv [NNV];
  logic [7:0] exp_cfg [NCFG];

  always #10 clk = ~clk;

  cfg_loader #(.RD_LAT(RD_LAT)) u_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic hread(input logic [15:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  // waits at negedges for done; returns busy-high cycle count
  task automatic wait_done(output int bcnt, output bit seen);
    bcnt = 0; seen = 0;
    for (int i = 0; i < 2000; i++) begin
      if (done) begin seen = 1; break; end
      if (busy) bcnt++;
      @(negedge clk);
    end
  endtask

  task automatic apply_download();
    for (int k = 0; k < NCFG; k++) exp_cfg[k] = exp_nv[k];
    exp_cfg[8'h90] = exp_cfg[8'h90] & 8'hFB;
  endtask

  task automatic t_reset();
    for (int k = 0; k < NNV; k++) exp_nv[k] = 8'((k * 7 + 3) % 256);
    repeat (3) @(negedge clk);
    chk(busy === 1'b1, "R1 busy in reset", int'(busy), 1);
    chk(done === 1'b0, "R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_boot();
    int bc; bit seen; logic [7:0] d;
    @(negedge clk);
    chk(busy === 1'b1, "R1 boot download running", int'(busy), 1);
    wait_done(bc, seen);
    chk(seen, "R1 boot done", int'(seen), 1);
    apply_download();
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", int'(done), 0);
    for (int k = 0; k < NCFG; k += 37) begin
      hread(16'(k), d);
      chk(d === exp_cfg[k], "R2 R3 boot image", int'(d), int'(exp_cfg[k]));
    end
    hread(16'h0090, d);
    chk(d === exp_cfg[8'h90], "R6 boot 90h", int'(d), int'(exp_cfg[8'h90]));
    hread(16'h00DF, d);
    chk(d === exp_cfg[8'hDF], "R3 last byte", int'(d), int'(exp_cfg[8'hDF]));
  endtask

  task automatic t_idle_write();
    logic [7:0] d;
    hwrite(16'h0010, 8'hA5);
    hread(16'h0010, d);
    chk(d === 8'hA5, "R10 idle reg write", int'(d), 8'hA5);
    hwrite(16'h0090, 8'h03);
    chk(busy === 1'b0, "R5 no start without bit2", int'(busy), 0);
    hread(16'h0090, d);
    chk(d === 8'h03, "R5 plain store 90h", int'(d), 8'h03);
    hwrite(16'h00E5, 8'h77);
    hread(16'h00E5, d);
    chk(d === 8'h00, "R4 read above DFh", int'(d), 0);
  endtask

  task automatic t_user_dl();
    int bc; bit seen; logic [7:0] d; int errs;
    for (int k = 0; k < NCFG; k++) begin
      exp_nv[k] = 8'(k) ^ 8'hC3;
      hwrite(16'hF800 + 16'(k), exp_nv[k]);
    end
    exp_nv[8'h90] = 8'hFF;
    hwrite(16'hF890, 8'hFF);
    hwrite(16'hF8E0, 8'h11);
    hwrite(16'hF9FF, 8'h22);
    hwrite(16'h0005, 8'h99);
    hwrite(16'h0090, 8'h04);
    wait_done(bc, seen);
    chk(seen, "R5 user download done", int'(seen), 1);
    chk(bc == NCFG + RD_LAT, "R7 busy length", bc, NCFG + RD_LAT);
    chk(busy === 1'b0, "R8 busy low with done", int'(busy), 0);
    apply_download();
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", int'(done), 0);
    errs = 0;
    for (int k = 0; k < NCFG; k++) begin
      hread(16'(k), d);
      if (d !== exp_cfg[k]) begin
        errs++;
        if (errs == 1) chk(1'b0, "R3 copied byte", int'(d), int'(exp_cfg[k]));
      end
    end
    if (errs == 0) chk(1'b1, "R3 all bytes", 0, 0);
    hread(16'h0090, d);
    chk(d === 8'hFB, "R6 trigger bit cleared", int'(d), 8'hFB);
    hread(16'h00E0, d);
    chk(d === 8'h00, "R4 page 7 not copied", int'(d), 0);
    repeat (5) @(negedge clk);
    chk(busy === 1'b0, "R6 no restart", int'(busy), 0);
  endtask

  task automatic t_lockout();
    int bc; bit seen; logic [7:0] d; bit stay_low;
    hwrite(16'h0090, 8'h04);
    repeat (10) @(negedge clk);
    hread(16'h0010, d);
    chk(d === 8'h00, "R9 read locked", int'(d), 0);
    hwrite(16'h0020, 8'h5A);
    hwrite(16'h0090, 8'h04);
    hwrite(16'hF821, 8'hEE);
    wait_done(bc, seen);
    chk(seen, "R9 download done", int'(seen), 1);
    apply_download();
    @(negedge clk);
    hread(16'h0020, d);
    chk(d === exp_cfg[8'h20], "R9 write ignored", int'(d), int'(exp_cfg[8'h20]));
    stay_low = 1;
    for (int i = 0; i < 20; i++) begin
      if (busy) stay_low = 0;
      @(negedge clk);
    end
    chk(stay_low, "R9 trigger ignored", int'(stay_low), 1);
    // store write during busy must be dropped: copy again and check 21h
    hwrite(16'h0090, 8'h04);
    wait_done(bc, seen);
    apply_download();
    @(negedge clk);
    hread(16'h0021, d);
    chk(d === exp_cfg[8'h21], "R9 store write ignored", int'(d), int'(exp_cfg[8'h21]));
  endtask

  initial begin
    #(150000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_boot();
    t_idle_write();
    t_user_dl();
    t_lockout();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule